// File: doc/BRIEF.md
# Symmetric Counter Gray-Scale PWM

The block turns a set of per-channel gray levels into centred pulse-width-modulated outputs. All channels share one master counter. A load-count pulse starts a cycle with the counter at its all-ones value, counting down. After the counter reaches one it turns round and counts back up to all ones. Each step of the counter is one edge of an external count clock, and both its rising and its falling edges count. The count clock is brought into the system clock domain by a synchronizer, and every change of its level is one step.

A channel turns on at the step where the falling count equals its level. It stays on until the rising count has passed its level again. A channel with a larger level therefore gets a wider pulse, and every pulse is centred on the turnaround. The blank input stops the cycle at once: the counter returns to all ones and every output goes low. Load-count pulses that arrive during a cycle are ignored.

Top module: `symgray_pwm`

## Requirements
- R1: Each change of level on `cnt_clk`, rising or falling, advances the counter by exactly one step. The step reaches the outputs at the (SYNC_STAGES+1)-th rising `clk` edge after the change.
- R2: A `load_cnt` pulse while idle starts a cycle at the next rising `clk` edge, with the counter at all ones and counting down. `cycle_done` drops in the same edge. That edge is step 0, and channels whose level is all ones turn on at it.
- R3: While counting down, a channel turns on at the step where the counter equals its level, which is step (2^LVL_W-1) - level.
- R4: At the turnaround the value 1 is held for one extra step that already belongs to the up phase. The up count then continues from 1, so a level-1 channel is high for exactly 2 steps.
- R5: While counting up, a high channel turns off at the step after the counter equals its level. Every pulse with a nonzero level is exactly 2*level count steps wide.
- R6: A channel with level 0 never goes high.
- R7: The step after the up count reaches all ones ends the cycle. That is step 2*(2^LVL_W-1): all outputs are low and `cycle_done` is high. Reset leaves the block in the same idle state.
- R8: `blank` forces the counter to all ones, the block to idle and every output low at the next rising `clk` edge. It takes priority over `load_cnt` and over count steps.
- R9: A `load_cnt` pulse during an active cycle changes neither the outputs nor the cycle's schedule.
- R10: Count-clock changes while idle do not move the counter: the next cycle still starts at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clk | input | 1 | Count clock. Both edges are steps; it is sampled through a synchronizer |
| load_cnt | input | 1 | Start pulse, synchronous to `clk` |
| blank | input | 1 | Synchronous stop that clears all outputs |
| levels | input | NUM_CH*LVL_W | Channel levels packed together; channel i uses bits [i*LVL_W +: LVL_W] |
| ch_out | output | NUM_CH | PWM output per channel |
| cycle_done | output | 1 | High while idle and ready for a new cycle |

## Verification
A count-clock change shows up on `ch_out` and `cycle_done` at the third rising clock edge after it: two synchronizer stages plus the output register. `load_cnt` and `blank` act at the first rising edge. The bench drives every input at a falling edge. After a count-clock change it waits SYNC_STAGES+2 falling edges before it samples, and after load or blank it waits one falling edge. One check samples one falling edge early to confirm that the outputs have not moved yet. Expected outputs come from the step index alone: a channel is high when the step lies in [M-level, M+level), where M is the all-ones count.

// File: rtl/symgray_pkg.sv
package symgray_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DOWN = 2'd1,
      PH_UP   = 2'd2
   } sweep_phase_e;

endpackage

// File: rtl/sg_edge_sync.sv
module sg_edge_sync #(
   parameter int SYNC_STAGES = 2,
   parameter bit BOTH_EDGES  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic step_o
);
   localparam int MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("sg_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [MSB:0] sync_q;
   logic         last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[MSB-1:0], async_in};
         last_q <= sync_q[MSB];
      end
   end

   if (BOTH_EDGES) begin : g_dual
      assign step_o = sync_q[MSB] ^ last_q;
   end else begin : g_rise
      assign step_o = sync_q[MSB] & ~last_q;
   end

endmodule

// File: rtl/sg_sweep_ctr.sv
module sg_sweep_ctr
   import symgray_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blank,
   input  logic             load,
   input  logic             cnt_step,
   output logic [CNT_W-1:0] cur_cnt,
   output sweep_phase_e     cur_phase,
   output logic [CNT_W-1:0] nxt_cnt,
   output sweep_phase_e     nxt_phase,
   output logic             adv
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("sg_sweep_ctr: CNT_W must be at least 2");
   end

   always_comb begin
      nxt_cnt   = cur_cnt;
      nxt_phase = cur_phase;
      adv       = 1'b0;
      if (blank) begin
         nxt_cnt   = CNT_MAX;
         nxt_phase = PH_IDLE;
      end else begin
         unique case (cur_phase)
            PH_IDLE: begin
               if (load) begin
                  adv       = 1'b1;
                  nxt_cnt   = CNT_MAX;
                  nxt_phase = PH_DOWN;
               end
            end
            PH_DOWN: begin
               if (cnt_step) begin
                  adv = 1'b1;
                  if (cur_cnt == CNT_ONE) begin
                     nxt_phase = PH_UP;
                  end else begin
                     nxt_cnt = cur_cnt - CNT_ONE;
                  end
               end
            end
            PH_UP: begin
               if (cnt_step) begin
                  adv = 1'b1;
                  if (cur_cnt == CNT_MAX) begin
                     nxt_phase = PH_IDLE;
                  end else begin
                     nxt_cnt = cur_cnt + CNT_ONE;
                  end
               end
            end
            default: begin
               nxt_cnt   = CNT_MAX;
               nxt_phase = PH_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_cnt   <= CNT_MAX;
         cur_phase <= PH_IDLE;
      end else begin
         cur_cnt   <= nxt_cnt;
         cur_phase <= nxt_phase;
      end
   end

   a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase == PH_IDLE && load && !blank) |=> (cur_phase == PH_DOWN && cur_cnt == CNT_MAX));

   a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase == PH_DOWN && cur_cnt == CNT_ONE && cnt_step && !blank)
         |=> (cur_phase == PH_UP && cur_cnt == CNT_ONE));

   a_r9_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase != PH_IDLE && load && !cnt_step && !blank) |=> ($stable(cur_cnt) && $stable(cur_phase)));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase == PH_IDLE && !load) |=> (cur_phase == PH_IDLE));

   a_r8_blank_reset: assert property (@(posedge clk) disable iff (!rst_n)
      blank |=> (cur_phase == PH_IDLE && cur_cnt == CNT_MAX));

   a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase != PH_IDLE && cnt_step && !blank)
         |=> (cur_phase == PH_IDLE
              || cur_cnt == $past(cur_cnt) + CNT_ONE
              || cur_cnt == $past(cur_cnt) - CNT_ONE
              || (cur_cnt == CNT_ONE && $past(cur_cnt) == CNT_ONE)));

endmodule

// File: rtl/sg_chan_cmp.sv
module sg_chan_cmp
   import symgray_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blank,
   input  logic [CNT_W-1:0] level,
   input  logic             adv,
   input  sweep_phase_e     cur_phase,
   input  logic [CNT_W-1:0] cur_cnt,
   input  sweep_phase_e     nxt_phase,
   input  logic [CNT_W-1:0] nxt_cnt,
   output logic             out_q
);
   logic lvl_nz;
   logic hit_down;
   logic hit_up;

   assign lvl_nz   = (level != '0);
   assign hit_down = lvl_nz && (nxt_phase == PH_DOWN) && (nxt_cnt == level);
   assign hit_up   = (cur_phase == PH_UP) && (cur_cnt == level);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else if (blank) begin
         out_q <= 1'b0;
      end else if (adv) begin
         if (nxt_phase == PH_IDLE || hit_up) begin
            out_q <= 1'b0;
         end else if (hit_down) begin
            out_q <= 1'b1;
         end
      end
   end

   a_r6_no_zero_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> ($past(level) != '0));

   a_r3_rise_in_down: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> ($past(nxt_phase) == PH_DOWN));

   a_r5_fall_on_up: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_q) |-> ($past(blank) || $past(cur_phase) == PH_UP));

endmodule

// File: rtl/symgray_pwm.sv
module symgray_pwm
   import symgray_pkg::*;
#(
   parameter int NUM_CH      = 32,
   parameter int LVL_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit BOTH_EDGES  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cnt_clk,
   input  logic                    load_cnt,
   input  logic                    blank,
   input  logic [NUM_CH*LVL_W-1:0] levels,
   output logic [NUM_CH-1:0]       ch_out,
   output logic                    cycle_done
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("symgray_pwm: NUM_CH must be at least 1");
   end
   if (LVL_W < 2 || LVL_W > 16) begin : g_bad_lvl
      $error("symgray_pwm: LVL_W must lie in 2..16");
   end

   logic             cnt_step;
   logic [LVL_W-1:0] cur_cnt;
   logic [LVL_W-1:0] nxt_cnt;
   sweep_phase_e     cur_phase;
   sweep_phase_e     nxt_phase;
   logic             adv;

   sg_edge_sync #(
      .SYNC_STAGES(SYNC_STAGES),
      .BOTH_EDGES (BOTH_EDGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(cnt_clk),
      .step_o  (cnt_step)
   );

   sg_sweep_ctr #(
      .CNT_W(LVL_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .blank    (blank),
      .load     (load_cnt),
      .cnt_step (cnt_step),
      .cur_cnt  (cur_cnt),
      .cur_phase(cur_phase),
      .nxt_cnt  (nxt_cnt),
      .nxt_phase(nxt_phase),
      .adv      (adv)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      sg_chan_cmp #(
         .CNT_W(LVL_W)
      ) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .blank    (blank),
         .level    (levels[i*LVL_W +: LVL_W]),
         .adv      (adv),
         .cur_phase(cur_phase),
         .cur_cnt  (cur_cnt),
         .nxt_phase(nxt_phase),
         .nxt_cnt  (nxt_cnt),
         .out_q    (ch_out[i])
      );
   end

   assign cycle_done = (cur_phase == PH_IDLE);

   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |-> (ch_out == '0));

   a_r8_blank_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      blank |=> (ch_out == '0 && cycle_done));

endmodule

// File: tb/sim_symgray_pwm.sv
`timescale 1ns/1ps
module sim_symgray_pwm;
   localparam int NC = 16;
   localparam int LW = 4;
   localparam int SS = 2;
   localparam int M  = (1 << LW) - 1;
   localparam int LAST = 2 * M;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cnt_clk = 1'b0;
   logic             load_cnt = 1'b0;
   logic             blank = 1'b0;
   logic [NC*LW-1:0] levels = '0;
   logic [NC-1:0]    ch_out;
   logic             cycle_done;

   int checks = 0;
   int errors = 0;
   int lv [NC];

   always #2.5 clk = ~clk;

   symgray_pwm #(
      .NUM_CH     (NC),
      .LVL_W      (LW),
      .SYNC_STAGES(SS),
      .BOTH_EDGES (1'b1)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_clk   (cnt_clk),
      .load_cnt  (load_cnt),
      .blank     (blank),
      .levels    (levels),
      .ch_out    (ch_out),
      .cycle_done(cycle_done)
   );

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, got, exp, $time);
      end
   endtask

   task automatic apply_levels();
      for (int i = 0; i < NC; i++) levels[i*LW +: LW] = LW'(lv[i]);
   endtask

   function automatic int expect_outs(input int s);
      int v = 0;
      for (int i = 0; i < NC; i++) begin
         if (lv[i] != 0 && s >= M - lv[i] && s < M + lv[i]) v |= (1 << i);
      end
      return v;
   endfunction

   function automatic int zero_mask();
      int v = 0;
      for (int i = 0; i < NC; i++) if (lv[i] == 0) v |= (1 << i);
      return v;
   endfunction

   task automatic pulse_load();
      @(negedge clk);
      load_cnt = 1'b1;
      @(negedge clk);
      load_cnt = 1'b0;
   endtask

   task automatic toggle_wait();
      @(negedge clk);
      cnt_clk = ~cnt_clk;
      repeat (SS + 2) @(negedge clk);
   endtask

   // Full cycle; a mid-cycle load is pulsed after step load_at (R9) when load_at > 0
   task automatic run_cycle(input int load_at);
      int seen = 0;
      string tag;
      pulse_load();
      check("R2 outputs at step 0", int'(ch_out), expect_outs(0));
      check("R2 done low after load", int'(cycle_done), 0);
      seen |= int'(ch_out);
      for (int s = 1; s <= LAST; s++) begin
         toggle_wait();
         if (s < M) tag = "R3";
         else if (s <= M + 1) tag = "R4";
         else if (s < LAST) tag = "R5";
         else tag = "R7";
         check({tag, " outputs"}, int'(ch_out), expect_outs(s));
         check({tag, " cycle_done"}, int'(cycle_done), (s == LAST) ? 1 : 0);
         seen |= int'(ch_out);
         if (s == load_at) begin
            pulse_load();
            check("R9 outputs after late load", int'(ch_out), expect_outs(s));
            check("R9 done after late load", int'(cycle_done), 0);
         end
      end
      check("R6 zero-level channels stayed low", seen & zero_mask(), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R7: actual cycle not finished expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NC; i++) lv[i] = i;
      apply_levels();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 reset outputs", int'(ch_out), 0);
      check("R7 reset done", int'(cycle_done), 1);

      // R10: count edges while idle
      for (int k = 0; k < 3; k++) begin
         toggle_wait();
         check("R10 idle outputs", int'(ch_out), 0);
         check("R10 idle done", int'(cycle_done), 1);
      end

      // exhaustive sweep: every channel sees every level
      for (int rot = 0; rot < NC; rot++) begin
         for (int i = 0; i < NC; i++) lv[i] = (i + rot) % (M + 1);
         apply_levels();
         run_cycle(0);
      end

      // R9: load pulse during a cycle
      run_cycle(7);

      // R1: latency of a count step and response to both edges
      for (int i = 0; i < NC; i++) lv[i] = M - 1;
      apply_levels();
      pulse_load();
      check("R1 step 0 outputs", int'(ch_out), 0);
      @(negedge clk);
      cnt_clk = ~cnt_clk;
      repeat (SS) @(negedge clk);
      check("R1 not yet advanced", int'(ch_out), 0);
      @(negedge clk);
      check("R1 advanced on third edge", int'(ch_out), (1 << NC) - 1);

      // R8: blank mid-cycle, together with a count edge
      @(negedge clk);
      blank = 1'b1;
      cnt_clk = ~cnt_clk;
      @(negedge clk);
      blank = 1'b0;
      check("R8 blank clears outputs", int'(ch_out), 0);
      check("R8 blank returns idle", int'(cycle_done), 1);
      repeat (SS + 2) @(negedge clk);
      check("R8 count edge under blank ignored", int'(ch_out), 0);

      // R8: blank beats load
      @(negedge clk);
      blank = 1'b1;
      load_cnt = 1'b1;
      @(negedge clk);
      blank = 1'b0;
      load_cnt = 1'b0;
      check("R8 blank over load done", int'(cycle_done), 1);
      check("R8 blank over load outputs", int'(ch_out), 0);

      // R10 after blank: next cycle starts at step 0; level-1 and full-scale in the mix
      lv[0] = 1; lv[1] = M; lv[2] = 0;
      apply_levels();
      run_cycle(0);

      // random levels
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < NC; i++) lv[i] = int'($urandom % (M + 1));
         apply_levels();
         run_cycle(0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule